// File: doc/BRIEF.md
# Register Rename Map Table

This block renames the registers of one instruction per clock. Each instruction carries two architectural source indices, an optional destination index and a valid flag. A table indexed by architectural register number records which temporary register last received a result for that register. Each source operand is translated through this table. If no earlier instruction has written the register, the architectural name passes through unchanged. An instruction with a destination is then handed the next temporary tag, and its table entry is updated at the clock edge.

Tags are given out strictly in increasing order, starting from a fixed first index. There is no recycling. Once the highest tag has been handed out, the block raises a stall and stays stalled until reset. The source translation is combinational from the current table contents. Table and allocator changes take effect at the next rising clock edge.

Top module: `rename_map_top`

## Requirements
- R1: After reset, `stall` is low and the first instruction that has a destination receives tag 9.
- R2: Each later destination receives the tag one above the previous one. Tags are contiguous and increase by one.
- R3: A source whose register has been written since reset is output as the tag of the most recent writer, with its `is_temp` flag high.
- R4: A source whose register has not been written since reset is output as its architectural index, zero-extended to the tag width, with `is_temp` low. Source translation is driven at all times, whatever the state of `in_valid`.
- R5: Within one instruction, the sources read the table before that instruction's own destination is recorded. A source equal to the destination therefore sees the previous producer, and later instructions see the new tag.
- R6: A valid instruction with `in_has_dst` low allocates no tag, leaves `out_dst_alloc` low, and leaves the table and the next tag unchanged.
- R7: When `in_valid` is low, nothing is allocated and neither the table nor the next tag changes.
- R8: In the cycle after tag 63 is handed out, `stall` goes high and stays high until reset. While stalled, `out_valid` and `out_dst_alloc` are low and valid inputs do not change the table.
- R9: `out_valid` is high exactly when `in_valid` is high and `stall` is low. `out_dst_alloc` is high exactly when `out_valid` and `in_has_dst` are both high.
- R10: A reset applied mid-run clears every mapping and restarts allocation at tag 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_src_a | input | 5 | First architectural source index |
| in_src_b | input | 5 | Second architectural source index |
| in_has_dst | input | 1 | The instruction writes a destination |
| in_dst | input | 5 | Architectural destination index |
| out_valid | output | 1 | Instruction accepted this cycle |
| out_src_a_tag | output | 6 | Renamed first source (tag or architectural index) |
| out_src_a_is_temp | output | 1 | First source is a temporary tag |
| out_src_b_tag | output | 6 | Renamed second source |
| out_src_b_is_temp | output | 1 | Second source is a temporary tag |
| out_dst_tag | output | 6 | Tag assigned to the destination |
| out_dst_alloc | output | 1 | A tag was assigned this cycle |
| stall | output | 1 | Tag pool exhausted; inputs ignored |

## Verification
The bench targets four corner cases.

- A source that names the same register as its own destination must see the previous producer. A design that writes before it reads would return its own fresh tag.
- Stores and idle cycles must not consume a tag. If they did, every later tag would shift by one and the table would be corrupted.
- After the last tag, the bench checks that stall holds and that a write attempted while stalled does not land in the table.
- A mid-run reset must clear every mapping. A design that keeps stale mappings would wrongly flag a never-written register as a temporary.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int unsigned ARCH_REGS_DEF = 32;
    localparam int unsigned TAG_COUNT_DEF = 64;
    localparam int unsigned FIRST_TAG_DEF = 9;
    localparam int unsigned NUM_SRC       = 2;
endpackage

// File: rtl/rename_tag_alloc.sv
module rename_tag_alloc #(
    parameter int unsigned TAG_COUNT = rename_pkg::TAG_COUNT_DEF,
    parameter int unsigned FIRST_TAG = rename_pkg::FIRST_TAG_DEF,
    localparam int unsigned TW       = $clog2(TAG_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic [TW-1:0] cur_tag,
    output logic          exhausted
);
    typedef struct packed {
        logic [TW-1:0] ptr;
        logic          done;
    } alloc_state_t;

    localparam logic [TW-1:0] LAST_TAG  = TW'(TAG_COUNT - 1);
    localparam logic [TW-1:0] START_TAG = TW'(FIRST_TAG);

    alloc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take && !st_q.done) begin
            if (st_q.ptr == LAST_TAG) begin
                st_d.done = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= START_TAG;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_tag   = st_q.ptr;
    assign exhausted = st_q.done;
endmodule

// File: rtl/rename_map_store.sv
module rename_map_store #(
    parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned TAG_COUNT = rename_pkg::TAG_COUNT_DEF,
    parameter int unsigned NRD       = rename_pkg::NUM_SRC,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned TW       = $clog2(TAG_COUNT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][AW-1:0]  rd_idx,
    output logic [NRD-1:0]          rd_vld,
    output logic [NRD-1:0][TW-1:0]  rd_tag,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_idx,
    input  logic [TW-1:0]           wr_tag
);
    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
    } map_entry_t;

    typedef struct packed {
        map_entry_t [ARCH_REGS-1:0] ent;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx].vld = 1'b1;
            st_d.ent[wr_idx].tag = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Reads see the registered contents only: lookups precede this cycle's update.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_vld[g] = st_q.ent[rd_idx[g]].vld;
        assign rd_tag[g] = st_q.ent[rd_idx[g]].tag;
    end
endmodule

// File: rtl/rename_src_sel.sv
module rename_src_sel #(
    parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned TAG_COUNT = rename_pkg::TAG_COUNT_DEF,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned TW       = $clog2(TAG_COUNT)
) (
    input  logic [AW-1:0] arch_idx,
    input  logic          map_vld,
    input  logic [TW-1:0] map_tag,
    output logic [TW-1:0] src_tag,
    output logic          src_is_temp
);
    always_comb begin
        if (map_vld) begin
            src_tag     = map_tag;
            src_is_temp = 1'b1;
        end else begin
            src_tag     = TW'(arch_idx);
            src_is_temp = 1'b0;
        end
    end
endmodule

// File: rtl/rename_map_top.sv
module rename_map_top #(
    parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned TAG_COUNT = rename_pkg::TAG_COUNT_DEF,
    parameter int unsigned FIRST_TAG = rename_pkg::FIRST_TAG_DEF,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned TW       = $clog2(TAG_COUNT),
    localparam int unsigned NS       = rename_pkg::NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_dst,
    output logic          out_valid,
    output logic [TW-1:0] out_src_a_tag,
    output logic          out_src_a_is_temp,
    output logic [TW-1:0] out_src_b_tag,
    output logic          out_src_b_is_temp,
    output logic [TW-1:0] out_dst_tag,
    output logic          out_dst_alloc,
    output logic          stall
);
    logic [NS-1:0][AW-1:0] src_idx;
    logic [NS-1:0]         map_vld;
    logic [NS-1:0][TW-1:0] map_tag;
    logic [NS-1:0][TW-1:0] ren_tag;
    logic [NS-1:0]         ren_temp;
    logic [TW-1:0]         alloc_ptr;
    logic                  pool_empty;
    logic                  accept;
    logic                  take;

    assign src_idx[0] = in_src_a;
    assign src_idx[1] = in_src_b;

    assign accept = in_valid && !pool_empty;
    assign take   = accept && in_has_dst;

    rename_map_store #(
        .ARCH_REGS (ARCH_REGS),
        .TAG_COUNT (TAG_COUNT),
        .NRD       (NS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (src_idx),
        .rd_vld (map_vld),
        .rd_tag (map_tag),
        .wr_en  (take),
        .wr_idx (in_dst),
        .wr_tag (alloc_ptr)
    );

    rename_tag_alloc #(
        .TAG_COUNT (TAG_COUNT),
        .FIRST_TAG (FIRST_TAG)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .cur_tag   (alloc_ptr),
        .exhausted (pool_empty)
    );

    for (genvar g = 0; g < NS; g++) begin : g_src
        rename_src_sel #(
            .ARCH_REGS (ARCH_REGS),
            .TAG_COUNT (TAG_COUNT)
        ) u_sel (
            .arch_idx    (src_idx[g]),
            .map_vld     (map_vld[g]),
            .map_tag     (map_tag[g]),
            .src_tag     (ren_tag[g]),
            .src_is_temp (ren_temp[g])
        );
    end

    assign out_valid         = accept;
    assign out_src_a_tag     = ren_tag[0];
    assign out_src_a_is_temp = ren_temp[0];
    assign out_src_b_tag     = ren_tag[1];
    assign out_src_b_is_temp = ren_temp[1];
    assign out_dst_tag       = alloc_ptr;
    assign out_dst_alloc     = take;
    assign stall             = pool_empty;
endmodule

// File: rtl/rename_map_checker.sv
module rename_map_checker #(
    parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned TAG_COUNT = rename_pkg::TAG_COUNT_DEF,
    parameter int unsigned FIRST_TAG = rename_pkg::FIRST_TAG_DEF,
    localparam int unsigned TW       = $clog2(TAG_COUNT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_has_dst,
    input logic          out_valid,
    input logic [TW-1:0] out_src_a_tag,
    input logic          out_src_a_is_temp,
    input logic [TW-1:0] out_dst_tag,
    input logic          out_dst_alloc,
    input logic          stall,
    input logic [TW-1:0] alloc_ptr
);
    logic          seen_q;
    logic [TW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (out_dst_alloc) begin
            seen_q <= 1'b1;
            last_q <= out_dst_tag;
        end
    end

    assert_first_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dst_alloc && !seen_q) |-> (out_dst_tag == TW'(FIRST_TAG)));

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dst_alloc && seen_q) |-> (out_dst_tag == last_q + TW'(1)));

    assert_temp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_src_a_is_temp |-> (out_src_a_tag >= TW'(FIRST_TAG)));

    assert_arch_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_src_a_is_temp |-> (out_src_a_tag < TW'(ARCH_REGS)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_dst_alloc && !stall) |=> $stable(alloc_ptr));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!out_valid && !out_dst_alloc));

    assert_stall_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> stall);

    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!out_valid && !out_dst_alloc));

    assert_alloc_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_dst_alloc |-> (out_valid && in_has_dst));
endmodule

bind rename_map_top rename_map_checker #(
    .ARCH_REGS (ARCH_REGS),
    .TAG_COUNT (TAG_COUNT),
    .FIRST_TAG (FIRST_TAG)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .in_has_dst        (in_has_dst),
    .out_valid         (out_valid),
    .out_src_a_tag     (out_src_a_tag),
    .out_src_a_is_temp (out_src_a_is_temp),
    .out_dst_tag       (out_dst_tag),
    .out_dst_alloc     (out_dst_alloc),
    .stall             (stall),
    .alloc_ptr         (alloc_ptr)
);

// File: tb/rename_map_top_tb_top.sv
module rename_map_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [4:0] in_src_a, in_src_b, in_dst;
    logic       in_has_dst;
    logic       out_valid;
    logic [5:0] out_src_a_tag, out_src_b_tag, out_dst_tag;
    logic       out_src_a_is_temp, out_src_b_is_temp, out_dst_alloc, stall;

    int checks = 0;
    int fails  = 0;
    int exp_next;

    always #10 clk = ~clk;

    rename_map_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_has_dst(in_has_dst), .in_dst(in_dst),
        .out_valid(out_valid),
        .out_src_a_tag(out_src_a_tag), .out_src_a_is_temp(out_src_a_is_temp),
        .out_src_b_tag(out_src_b_tag), .out_src_b_is_temp(out_src_b_is_temp),
        .out_dst_tag(out_dst_tag), .out_dst_alloc(out_dst_alloc),
        .stall(stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present inputs just after a falling edge and let them settle.
    task automatic drive(input logic v, input int a, input int b, input logic hd, input int d);
        in_valid   = v;
        in_src_a   = 5'(a);
        in_src_b   = 5'(b);
        in_has_dst = hd;
        in_dst     = 5'(d);
        #3;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_src(input string req, input int tag_a, input int tmp_a,
                           input int tag_b, input int tmp_b);
        chk(req, "src_a tag", out_src_a_tag, tag_a);
        chk(req, "src_a temp", out_src_a_is_temp, tmp_a);
        chk(req, "src_b tag", out_src_b_tag, tag_b);
        chk(req, "src_b temp", out_src_b_is_temp, tmp_b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 0, 0, 1'b0, 0);
        step();
        step();
        rst_n = 1'b1;
        exp_next = 9;
    endtask

    // Instruction with a destination: check sources, allocation, then clock it in.
    task automatic rename_dst(input string req, input int a, input int b, input int d,
                              input int ta, input int pa, input int tb, input int pb);
        drive(1'b1, a, b, 1'b1, d);
        chk_src(req, ta, pa, tb, pb);
        chk("R9", "out_valid", out_valid, 1);
        chk("R2", "dst alloc", out_dst_alloc, 1);
        chk("R2", "dst tag", out_dst_tag, exp_next);
        exp_next++;
        step();
    endtask

    task automatic t_reset_state();
        do_reset();
        drive(1'b0, 0, 31, 1'b0, 0);
        chk("R1", "stall after reset", stall, 0);
        chk_src("R4", 0, 0, 31, 0);
        chk("R9", "idle out_valid", out_valid, 0);
    endtask

    task automatic t_loop_body();
        // r20/r21 are base registers never written.
        rename_dst("R1", 20, 20, 2, 20, 0, 20, 0);      // load r2 -> T9
        rename_dst("R3", 0, 2, 5, 0, 0, 9, 1);          // mul r5 = r0*r2 -> T10
        rename_dst("R3", 0, 2, 8, 0, 0, 9, 1);          // div r8 -> T11
        rename_dst("R4", 21, 21, 4, 21, 0, 21, 0);      // load r4 -> T12
        rename_dst("R3", 0, 4, 6, 0, 0, 12, 1);         // add r6 -> T13
        rename_dst("R3", 8, 2, 10, 11, 1, 9, 1);        // add r10 -> T14
    endtask

    task automatic t_store();
        drive(1'b1, 4, 21, 1'b0, 4);
        chk_src("R6", 12, 1, 21, 0);
        chk("R6", "store out_valid", out_valid, 1);
        chk("R6", "store alloc", out_dst_alloc, 0);
        step();
        drive(1'b0, 4, 10, 1'b0, 0);
        chk_src("R6", 12, 1, 14, 1);
        rename_dst("R6", 10, 10, 1, 14, 1, 14, 1);      // next tag still follows T14
    endtask

    task automatic t_read_before_write();
        int t = exp_next;
        rename_dst("R5", 5, 2, 5, 10, 1, 9, 1);
        drive(1'b0, 5, 5, 1'b0, 0);
        chk_src("R5", t, 1, t, 1);
    endtask

    task automatic t_idle();
        drive(1'b0, 0, 0, 1'b1, 5);
        chk("R7", "idle alloc", out_dst_alloc, 0);
        chk("R7", "idle out_valid", out_valid, 0);
        step();
        drive(1'b0, 5, 0, 1'b0, 0);
        chk("R7", "r5 map kept", out_src_a_tag, exp_next - 1);
        rename_dst("R7", 0, 0, 9, 0, 0, 0, 0);
    endtask

    task automatic t_exhaust();
        while (exp_next <= 63) begin
            drive(1'b1, 0, 0, 1'b1, 7);
            chk("R2", "bulk dst tag", out_dst_tag, exp_next);
            chk("R8", "no stall yet", stall, 0);
            exp_next++;
            step();
        end
        drive(1'b1, 7, 3, 1'b1, 3);
        chk("R8", "stall high", stall, 1);
        chk("R8", "stalled out_valid", out_valid, 0);
        chk("R8", "stalled alloc", out_dst_alloc, 0);
        chk_src("R8", 63, 1, 3, 0);
        step();
        drive(1'b0, 3, 7, 1'b0, 0);
        chk_src("R8", 3, 0, 63, 1);
        chk("R8", "stall sticky", stall, 1);
        step();
        chk("R8", "stall still", stall, 1);
    endtask

    task automatic t_mid_reset();
        do_reset();
        drive(1'b0, 7, 5, 1'b0, 0);
        chk("R10", "stall cleared", stall, 0);
        chk_src("R10", 7, 0, 5, 0);
        rename_dst("R10", 7, 2, 7, 7, 0, 2, 0);
        drive(1'b0, 7, 2, 1'b0, 0);
        chk_src("R10", 9, 1, 2, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        exp_next = 9;
        drive(1'b0, 0, 0, 1'b0, 0);
        t_reset_state();
        t_loop_body();
        t_store();
        t_read_before_write();
        t_idle();
        t_exhaust();
        t_mid_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule